// File: doc/BRIEF.md
# RAID-6 Partial Parity Update Engine

This block refreshes an existing P (plain XOR) and Q (Reed-Solomon) parity pair when only a contiguous band of data disks has changed. A command gives the lowest and highest changed disk index. The engine then takes one delta word per changed disk, starting at the highest index and working down. It folds the deltas into a partial P and a partial Q. Disks above the band take no part in the work. For each position below the band, the partial Q is multiplied by the field generator once, and the partial P is left as it is.

Once the band and the lower positions have been processed, the engine takes the old P and Q words of the stripe column. It XORs the partial results into them and presents the new parity pair. The output is held until the downstream side accepts it. Each word carries several independent byte lanes. Every lane works in GF(2^8) with the reduction polynomial 0x11D. Finding disk addresses and computing the deltas are done elsewhere.

Top module: `pqu_update_engine`

## Requirements
- R1: After reset, cmd_ready is 1 and data_ready, old_ready and out_valid are 0.
- R2: Once a command is accepted, data_ready stays high until exactly hi-lo+1 words have been taken, and cmd_ready stays low until the result has been accepted. At most one of cmd_ready, data_ready, old_ready and out_valid is high in any cycle.
- R3: out_p equals old_p XOR the XOR of every accepted data word.
- R4: In each byte lane j (bits 8j+7..8j), out_q equals old_q XOR the sum of 2^k·d_k in GF(2^8). Here d_k is the word for disk k. The first accepted word belongs to disk hi, and each following word belongs to the next lower disk.
- R5: Doubling a byte shifts it left by one bit and XORs in 0x1d when the original top bit was 1.
- R6: After the last data word, old_ready stays low for exactly lo cycles and then rises. When lo is 0, old_ready is high in the cycle right after the last word.
- R7: out_valid rises in the cycle after the old P/Q handshake.
- R8: While out_valid is high and out_ready is low, out_valid, out_p and out_q hold their values. The cycle after the output handshake, cmd_ready is high again.
- R9: Values on the data or old-parity inputs have no effect on the result while the matching ready signal is low.
- R10: When lo equals hi, exactly one data word is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command accepted |
| cmd_lo | input | IDX_W | Lowest changed disk index |
| cmd_hi | input | IDX_W | Highest changed disk index (at least cmd_lo) |
| data_valid | input | 1 | Delta word offered |
| data_ready | output | 1 | Delta word accepted |
| data_word | input | 8*LANES | Delta word, highest disk first |
| old_valid | input | 1 | Old parity offered |
| old_ready | output | 1 | Old parity accepted |
| old_p | input | 8*LANES | Existing P word |
| old_q | input | 8*LANES | Existing Q word |
| out_valid | output | 1 | New parity available |
| out_ready | input | 1 | New parity taken |
| out_p | output | 8*LANES | Updated P word |
| out_q | output | 8*LANES | Updated Q word |

## Verification
The hardest state to reach from the ports is a doubling-only phase that runs for many cycles while both input streams keep offering values that must be ignored. The same run also needs bytes whose top bit keeps being set, so that the 0x1d reduction fires repeatedly. The stimulus drives junk on the data and old-parity inputs whenever their ready is low. It uses bands that sit high in the index range and top-bit-heavy delta patterns. It adds gaps in the data stream and holds back the output. The expected Q is computed by a general field multiply with explicit generator powers, not by the step-by-step recurrence.

// File: rtl/pqu_pkg.sv
// Shared types and the GF(2^8) doubling helper for the partial parity engine.
package pqu_pkg;

    // Operating phases of the engine, one per stage of an update.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_DATA  = 3'd1,
        PH_SHIFT = 3'd2,
        PH_MERGE = 3'd3,
        PH_OUT   = 3'd4
    } pqu_phase_e;

    // Low byte of the reduction polynomial x^8+x^4+x^3+x^2+1.
    localparam logic [7:0] GF_TAIL = 8'h1d;

    // Multiply one field element by the generator 2.
    function automatic logic [7:0] gf_dbl(input logic [7:0] b);
        return {b[6:0], 1'b0} ^ (b[7] ? GF_TAIL : 8'h00);
    endfunction

endpackage

// File: rtl/pqu_ctrl.sv
// Phase sequencer. Accepts a command, counts the band's data words, then
// counts the doubling-only cycles, then waits for old parity and the output
// handshake. Assumes cmd_hi >= cmd_lo.
module pqu_ctrl #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [IDX_W-1:0] cmd_lo,
    input  logic [IDX_W-1:0] cmd_hi,
    input  logic             data_valid,
    input  logic             old_valid,
    input  logic             out_ready,
    output logic             cmd_ready,
    output logic             data_ready,
    output logic             old_ready,
    output logic             out_valid,
    output logic             acc_first,
    output logic             acc_step,
    output logic             acc_shift,
    output logic             mrg_load
);
    import pqu_pkg::*;

    localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

    pqu_phase_e       phase;
    logic [IDX_W-1:0] cnt;
    logic [IDX_W-1:0] lo_q;
    logic             first_q;
    logic             data_fire;
    logic             old_fire;

    // Handshake signals and datapath strobes decoded from the phase.
    always_comb begin
        cmd_ready  = (phase == PH_IDLE);
        data_ready = (phase == PH_DATA);
        old_ready  = (phase == PH_MERGE);
        out_valid  = (phase == PH_OUT);
        data_fire  = data_ready && data_valid;
        old_fire   = old_ready && old_valid;
        acc_first  = data_fire && first_q;
        acc_step   = data_fire && !first_q;
        acc_shift  = (phase == PH_SHIFT);
        mrg_load   = old_fire;
    end

    // Phase register with word and doubling counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            lo_q    <= '0;
            first_q <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (cmd_valid) begin
                    phase   <= PH_DATA;
                    cnt     <= cmd_hi - cmd_lo;
                    lo_q    <= cmd_lo;
                    first_q <= 1'b1;
                end
                PH_DATA: if (data_valid) begin
                    first_q <= 1'b0;
                    if (cnt == '0) begin
                        cnt   <= lo_q;
                        phase <= (lo_q == '0) ? PH_MERGE : PH_SHIFT;
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                PH_SHIFT: begin
                    cnt <= cnt - ONE;
                    if (cnt == ONE) phase <= PH_MERGE;
                end
                PH_MERGE: if (old_valid) phase <= PH_OUT;
                PH_OUT:   if (out_ready) phase <= PH_IDLE;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pqu_accum.sv
// Partial P/Q accumulator. First word seeds both sums. Each later word is
// XORed into P, while Q is doubled and then XORed with the word. A shift
// strobe doubles Q alone. Byte lanes are independent.
module pqu_accum #(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_first,
    input  logic               acc_step,
    input  logic               acc_shift,
    input  logic [8*LANES-1:0] din,
    output logic [8*LANES-1:0] acc_p,
    output logic [8*LANES-1:0] acc_q
);
    import pqu_pkg::*;

    localparam int W = 8 * LANES;

    logic [W-1:0] q_dbl;

    // One doubler per byte lane.
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        always_comb q_dbl[8*ln +: 8] = gf_dbl(acc_q[8*ln +: 8]);
    end

    // Running sums updated by the sequencer's strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_p <= '0;
            acc_q <= '0;
        end else if (acc_first) begin
            acc_p <= din;
            acc_q <= din;
        end else if (acc_step) begin
            acc_p <= acc_p ^ din;
            acc_q <= q_dbl ^ din;
        end else if (acc_shift) begin
            acc_q <= q_dbl;
        end
    end

endmodule

// File: rtl/pqu_merge.sv
// Read-modify-write stage: folds the partial sums into the old parity when
// the old words are accepted and keeps the result until the next load.
module pqu_merge #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] old_p,
    input  logic [W-1:0] old_q,
    input  logic [W-1:0] acc_p,
    input  logic [W-1:0] acc_q,
    output logic [W-1:0] out_p,
    output logic [W-1:0] out_q
);

    // Capture the updated parity pair on the old-parity handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_p <= '0;
            out_q <= '0;
        end else if (load) begin
            out_p <= old_p ^ acc_p;
            out_q <= old_q ^ acc_q;
        end
    end

endmodule

// File: rtl/pqu_update_engine.sv
// Top of the partial P/Q update engine: sequencer, accumulator and merge
// stage. Assumes cmd_hi >= cmd_lo for every command.
module pqu_update_engine #(
    parameter int LANES = 4,
    parameter int IDX_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [IDX_W-1:0]   cmd_lo,
    input  logic [IDX_W-1:0]   cmd_hi,
    input  logic               data_valid,
    output logic               data_ready,
    input  logic [8*LANES-1:0] data_word,
    input  logic               old_valid,
    output logic               old_ready,
    input  logic [8*LANES-1:0] old_p,
    input  logic [8*LANES-1:0] old_q,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [8*LANES-1:0] out_p,
    output logic [8*LANES-1:0] out_q
);
    localparam int W = 8 * LANES;

    logic         acc_first;
    logic         acc_step;
    logic         acc_shift;
    logic         mrg_load;
    logic [W-1:0] acc_p;
    logic [W-1:0] acc_q;

    pqu_ctrl #(.IDX_W(IDX_W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_lo     (cmd_lo),
        .cmd_hi     (cmd_hi),
        .data_valid (data_valid),
        .old_valid  (old_valid),
        .out_ready  (out_ready),
        .cmd_ready  (cmd_ready),
        .data_ready (data_ready),
        .old_ready  (old_ready),
        .out_valid  (out_valid),
        .acc_first  (acc_first),
        .acc_step   (acc_step),
        .acc_shift  (acc_shift),
        .mrg_load   (mrg_load)
    );

    pqu_accum #(.LANES(LANES)) accum_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_first (acc_first),
        .acc_step  (acc_step),
        .acc_shift (acc_shift),
        .din       (data_word),
        .acc_p     (acc_p),
        .acc_q     (acc_q)
    );

    pqu_merge #(.W(W)) merge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (mrg_load),
        .old_p (old_p),
        .old_q (old_q),
        .acc_p (acc_p),
        .acc_q (acc_q),
        .out_p (out_p),
        .out_q (out_q)
    );

endmodule

// File: rtl/pqu_checker.sv
// Protocol and timing checks for the update engine, bound to its top.
// Counts band words and doubling cycles on its own to check the windows.
module pqu_checker #(
    parameter int LANES = 4,
    parameter int IDX_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic               cmd_ready,
    input logic [IDX_W-1:0]   cmd_lo,
    input logic [IDX_W-1:0]   cmd_hi,
    input logic               data_valid,
    input logic               data_ready,
    input logic               old_valid,
    input logic               old_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [8*LANES-1:0] out_p,
    input logic [8*LANES-1:0] out_q
);
    logic [IDX_W-1:0] cap_lo;
    logic [IDX_W-1:0] cap_hi;
    logic [IDX_W:0]   words;
    logic [IDX_W:0]   gap;
    logic [IDX_W:0]   span;

    // Number of words the current band should deliver.
    always_comb span = {1'b0, cap_hi} - {1'b0, cap_lo} + (IDX_W+1)'(1);

    // Track the band, words taken and idle cycles after the last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_lo <= '0;
            cap_hi <= '0;
            words  <= '0;
            gap    <= '0;
        end else if (cmd_valid && cmd_ready) begin
            cap_lo <= cmd_lo;
            cap_hi <= cmd_hi;
            words  <= '0;
        end else if (data_valid && data_ready) begin
            words <= words + (IDX_W+1)'(1);
            gap   <= '0;
        end else if (!cmd_ready && !data_ready && !old_ready && !out_valid) begin
            gap <= gap + (IDX_W+1)'(1);
        end
    end

    a_r2_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_ready, data_ready, old_ready, out_valid}));

    a_r2_word_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && data_ready) |-> (words < span));

    a_r6_shift_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(old_ready) |-> (gap == {1'b0, cap_lo}));

    a_r7_out_follows_old: assert property (@(posedge clk) disable iff (!rst_n)
        (old_valid && old_ready) |=> out_valid);

    a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_p) && $stable(out_q)));

    a_r8_back_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> cmd_ready);

endmodule

bind pqu_update_engine pqu_checker #(.LANES(LANES), .IDX_W(IDX_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_lo     (cmd_lo),
    .cmd_hi     (cmd_hi),
    .data_valid (data_valid),
    .data_ready (data_ready),
    .old_valid  (old_valid),
    .old_ready  (old_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_p      (out_p),
    .out_q      (out_q)
);

// File: tb/pqu_update_engine_tb_top.sv
`timescale 1ns/1ps
// Bench for the partial P/Q update engine: behavioural phase model compared
// every clock, result computed with a general GF(2^8) multiply.
module pqu_update_engine_tb_top;
    localparam int LANES = 4;
    localparam int IDX_W = 4;
    localparam int W     = 8 * LANES;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic             cmd_ready;
    logic [IDX_W-1:0] cmd_lo = '0;
    logic [IDX_W-1:0] cmd_hi = '0;
    logic             data_valid = 1'b0;
    logic             data_ready;
    logic [W-1:0]     data_word = '0;
    logic             old_valid = 1'b0;
    logic             old_ready;
    logic [W-1:0]     old_p = '0;
    logic [W-1:0]     old_q = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [W-1:0]     out_p;
    logic [W-1:0]     out_q;

    always #2.5 clk = ~clk;

    pqu_update_engine #(.LANES(LANES), .IDX_W(IDX_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_lo(cmd_lo), .cmd_hi(cmd_hi),
        .data_valid(data_valid), .data_ready(data_ready), .data_word(data_word),
        .old_valid(old_valid), .old_ready(old_ready), .old_p(old_p), .old_q(old_q),
        .out_valid(out_valid), .out_ready(out_ready), .out_p(out_p), .out_q(out_q)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // Model state: 0 idle, 1 data, 2 doubling, 3 old parity, 4 output.
    int           ph = 0;
    int           words_left = 0;
    int           dbl_left = 0;
    int           m_lo = 0;
    int           m_hi = 0;
    logic [W-1:0] dq[$];
    logic [W-1:0] exp_p = '0;
    logic [W-1:0] exp_q = '0;
    logic [W-1:0] stim_q[$];
    logic [31:0]  lfsr = 32'h1234_5678;
    logic [W-1:0] cap_p, cap_q;
    int           dut_words;

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 8'h00;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= x;
            x = x[7] ? ({x[6:0], 1'b0} ^ 8'h1d) : {x[6:0], 1'b0};
        end
        return r;
    endfunction

    function automatic logic [7:0] gpow(input int n);
        logic [7:0] r = 8'h01;
        for (int i = 0; i < n; i++) r = gmul(r, 8'h02);
        return r;
    endfunction

    function automatic logic [W-1:0] junk();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr ^ 32'h5a5a_a5a5;
    endfunction

    // Compare every port with the model after each edge.
    task automatic compare();
        chk(cmd_ready  == (ph == 0), "R1/R2 cmd_ready", W'(cmd_ready), W'(ph == 0));
        chk(data_ready == (ph == 1), "R2/R10 data_ready", W'(data_ready), W'(ph == 1));
        chk(old_ready  == (ph == 3), "R6 old_ready", W'(old_ready), W'(ph == 3));
        chk(out_valid  == (ph == 4), "R7/R8 out_valid", W'(out_valid), W'(ph == 4));
        if (ph == 4) begin
            chk(out_p == exp_p, "R3 out_p", out_p, exp_p);
            chk(out_q == exp_q, "R4 out_q", out_q, exp_q);
        end
    endtask

    // One clock: model handshakes from pre-edge inputs, then compare.
    task automatic tick();
        bit cf, df, of, xf;
        logic [W-1:0] dw, op, oq;
        int lo, hi;
        cf = (ph == 0) && cmd_valid;
        df = (ph == 1) && data_valid;
        of = (ph == 3) && old_valid;
        xf = (ph == 4) && out_ready;
        dw = data_word; op = old_p; oq = old_q;
        lo = int'(cmd_lo); hi = int'(cmd_hi);
        @(posedge clk);
        #1;
        cyc++;
        if (ph == 0 && cf) begin
            ph = 1; m_lo = lo; m_hi = hi; words_left = hi - lo + 1; dq.delete();
        end else if (ph == 1 && df) begin
            dq.push_back(dw);
            words_left--;
            if (words_left == 0) begin
                dbl_left = m_lo;
                ph = (m_lo == 0) ? 3 : 2;
            end
        end else if (ph == 2) begin
            dbl_left--;
            if (dbl_left == 0) ph = 3;
        end else if (ph == 3 && of) begin
            exp_p = op;
            exp_q = oq;
            foreach (dq[k]) begin
                exp_p ^= dq[k];
                for (int ln = 0; ln < LANES; ln++)
                    exp_q[8*ln +: 8] ^= gmul(gpow(m_hi - k), dq[k][8*ln +: 8]);
            end
            ph = 4;
        end else if (ph == 4 && xf) begin
            ph = 0;
        end
        compare();
    endtask

    // Run one complete update; stimulus words are taken from stim_q.
    task automatic run_op(input int lo, input int hi, input logic [W-1:0] op, input logic [W-1:0] oq,
                          input bit gaps, input bit jk, input int hold);
        int  idx = 0;
        int  held = 0;
        bit  done = 0;
        int  pre;
        dut_words = 0;
        while (!done) begin
            cmd_valid = 0; data_valid = 0; old_valid = 0; out_ready = 0;
            if (jk) begin
                data_word = junk(); old_p = junk(); old_q = junk();
            end
            case (ph)
                0: begin cmd_valid = 1; cmd_lo = IDX_W'(lo); cmd_hi = IDX_W'(hi); end
                1: begin
                    data_valid = gaps ? cyc[0] : 1'b1;
                    if (data_valid) data_word = stim_q[idx];
                    if (jk) old_valid = 1;
                end
                2: if (jk) begin data_valid = 1; old_valid = 0; end
                3: begin
                    old_valid = 1; old_p = op; old_q = oq;
                    if (jk) data_valid = 1;
                end
                default: begin
                    out_ready = (held >= hold);
                    held++;
                    if (jk) begin data_valid = 1; old_valid = 1; end
                    if (out_ready) begin cap_p = out_p; cap_q = out_q; end
                end
            endcase
            if (data_valid && data_ready) dut_words++;
            pre = ph;
            tick();
            if (pre == 1 && data_valid) idx++;
            if (pre == 4 && ph == 0) done = 1;
        end
        cmd_valid = 0; data_valid = 0; old_valid = 0; out_ready = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=%0d expected<200000", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        // R1: idle handshake state straight after reset.
        chk(cmd_ready == 1'b1, "R1 cmd_ready after reset", W'(cmd_ready), W'(1));
        chk(data_ready == 1'b0 && old_ready == 1'b0 && out_valid == 1'b0, "R1 other handshakes after reset",
            W'({data_ready, old_ready, out_valid}), W'(0));
        compare();

        // R10 and R6 with lo = 0: single word at disk 0.
        stim_q = '{32'hdead_beef};
        run_op(0, 0, 32'h0102_0304, 32'h1111_2222, 0, 0, 0);
        chk(dut_words == 1, "R10 one word at lo=hi=0", W'(dut_words), W'(1));
        chk(cap_p == (32'h0102_0304 ^ 32'hdead_beef), "R3 single word P", cap_p, 32'h0102_0304 ^ 32'hdead_beef);
        chk(cap_q == (32'h1111_2222 ^ 32'hdead_beef), "R4 single word Q", cap_q, 32'h1111_2222 ^ 32'hdead_beef);

        // R5: doubling with and without the top bit, one position below the band.
        stim_q = '{32'h8040_ff01};
        run_op(1, 1, 32'h0, 32'h0, 0, 0, 0);
        chk(cap_q == 32'h1d80_e302, "R5 doubling per lane", cap_q, 32'h1d80_e302);
        chk(cap_p == 32'h8040_ff01, "R3 P untouched by doubling", cap_p, 32'h8040_ff01);

        // Band from disk 0 with gaps in the data stream.
        stim_q = '{32'h0000_0001, 32'h8000_0080, 32'hffff_ffff, 32'h1234_5678, 32'h0f0f_f0f0, 32'h8181_8181};
        run_op(0, 5, 32'hcafe_f00d, 32'h0bad_c0de, 1, 0, 0);
        chk(dut_words == 6, "R2 word count 6", W'(dut_words), W'(6));

        // R10 at a non-zero band position with output backpressure (R8).
        stim_q = '{32'hfedc_ba98};
        run_op(3, 3, 32'h1357_9bdf, 32'h2468_ace0, 0, 0, 4);
        chk(dut_words == 1, "R10 one word at lo=hi=3", W'(dut_words), W'(1));

        // R9: junk on every input whose ready is low, top-bit-heavy data.
        stim_q = '{32'h8080_8080, 32'hc0c0_c0c0, 32'hff80_80ff, 32'h8001_0280,
                   32'h9090_9090, 32'ha5a5_a5a5, 32'h8f8f_8f8f, 32'hf0f0_0f0f};
        run_op(2, 9, 32'h0, 32'h0, 1, 1, 3);
        chk(dut_words == 8, "R2 word count 8", W'(dut_words), W'(8));
        chk(cap_p == exp_p && cap_q == exp_q, "R9 result unaffected by ignored inputs", cap_q, exp_q);

        // Band at the top of the index range, long doubling phase.
        stim_q = '{32'h8000_0000, 32'h0000_0080};
        run_op(14, 15, 32'h7777_7777, 32'h8888_8888, 0, 1, 1);
        chk(cap_q == exp_q, "R6 long doubling result", cap_q, exp_q);

        // Pseudo-random bands.
        for (int t = 0; t < 12; t++) begin
            logic [W-1:0] r = junk();
            int lo = int'(r[3:0]);
            int hi = lo + int'(r[7:4]) % (16 - lo);
            stim_q.delete();
            for (int k = 0; k <= hi - lo; k++) stim_q.push_back(junk());
            run_op(lo, hi, junk(), junk(), r[8], r[9], int'(r[11:10]));
            chk(dut_words == hi - lo + 1, "R2 random band word count", W'(dut_words), W'(hi - lo + 1));
        end

        repeat (2) tick();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule